// File: doc/BRIEF.md
# Power Domain On/Off Sequencer

This block switches one gated logic domain between powered and unpowered. It works through a fixed, safe order of steps. A single request line with a direction bit starts a sequence. The block then drives the power-switch enables, isolation, the active-low domain reset, clock gating, SRAM power-down and interconnect protection, one change at a time. Between some of these steps it waits for acknowledges from the analog switches, the SRAM macros and the interconnect.

Every wait is bounded by a cycle counter whose limit is derived from the clock frequency and a timeout in microseconds. If a wait expires, the sequence aborts and the outputs hold where they were. A sticky error flag is set, and the next accepted request clears it. Two mask registers set which SRAM acknowledges and which protection lanes take part. A write to these registers is accepted only when it carries a key.

Top module: `pwr_domain_seq`

## Requirements
- R1: After reset the domain is treated as off. The outputs are `dom_rst_n`=0, `iso_en`=1, `sw_main`=0, `sw_aux`=0, `clk_gate`=1, `sram_pd` all ones, `prot_en`=0, `busy`=0, `done`=0 and `err`=0, and `seq_state` reads 0 (idle).
- R2: A power-up request changes the outputs in this order, each change in a separate clock cycle: `sw_main` rises, `sw_aux` rises, `clk_gate` falls, `iso_en` falls, `dom_rst_n` rises, `sram_pd` clears, and `prot_en` clears.
- R3: After both switches are on, power-up does not go on until both `pwr_ok_main` and `pwr_ok_aux` are high. One high and one low is not taken as completion.
- R4: After `sram_pd` clears, power-up waits until every `sram_ack` bit enabled in the SRAM mask is low. Acknowledge bits outside the mask have no effect.
- R5: When the protection mask is non-zero, power-up ends by clearing `prot_en` and then waits until every masked `prot_ack` bit is low.
- R6: A power-down request changes the outputs in this order, each change in a separate cycle: `prot_en` is set to the mask, `sram_pd` sets to all ones, `iso_en` rises, `dom_rst_n` falls, `clk_gate` rises, `sw_main` falls, and `sw_aux` falls. The sequence completes when both power-good inputs are low.
- R7: Power-down waits until every masked `prot_ack` bit is high before it touches `sram_pd`. It waits until every masked `sram_ack` bit is high before it raises `iso_en`.
- R8: A zero protection mask skips the protection step and its wait. A zero SRAM mask makes the SRAM wait pass at once. Under the bench's environment, such a power-down shows `done` 9 cycles after the request cycle.
- R9: When a wait lasts LIMIT = CLK_MHZ*TIMEOUT_US cycles, the sequence returns to idle with `busy` low and the outputs held, and `err` goes high and stays high. The next accepted request clears `err` and runs the full sequence.
- R10: A configuration write takes effect only when `cfg_wdata[31:16]` is 0x0B16 and `cfg_wdata[0]` is 1. `cfg_sel`=0 selects the SRAM mask and `cfg_sel`=1 the protection mask. The mask value is taken from `cfg_wdata` starting at bit 4.
- R11: A request that arrives while `busy` is high is ignored.
- R12: A request for the state the domain is already in changes no control output. `busy` stays low and `done` pulses in the next cycle.
- R13: `busy` is high for the whole of a sequence. `done` is a one-cycle pulse, raised when `busy` falls on success.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, sampled in idle |
| req_on | input | 1 | Requested state: 1 power up, 0 power down |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Register select: 0 SRAM mask, 1 protection mask |
| cfg_wdata | input | 32 | Key, enable bit and mask value |
| pwr_ok_main | input | 1 | Power-good status, first indication |
| pwr_ok_aux | input | 1 | Power-good status, second indication |
| sram_ack | input | SRAM_W | SRAM power-down acknowledges |
| prot_ack | input | PROT_W | Protection acknowledges |
| dom_rst_n | output | 1 | Domain reset, active low |
| iso_en | output | 1 | Output isolation enable |
| sw_main | output | 1 | First power-switch enable |
| sw_aux | output | 1 | Second power-switch enable |
| clk_gate | output | 1 | Domain clock disable |
| sram_pd | output | SRAM_W | SRAM power-down controls |
| prot_en | output | PROT_W | Protection enable lanes |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky timeout flag |
| seq_state | output | 5 | Current sequencer step |

## Verification
Power-up is run three ways. It is run with the second power-good held low, which shows whether a disagreement between the two status inputs is mistaken for completion. It is run with one masked and one unmasked SRAM acknowledge stuck high, which shows whether the mask controls the wait. It is run with a protection acknowledge held high, which shows whether the release of protection is waited on. Power-down is run with a masked protection lane and a masked SRAM lane held low, so that each wait is shown to gate the next step. It is also run with both masks zero, where the exact completion cycle separates a skipped step from an immediate one. A switch status that never arrives exercises the timeout. Rejected writes show up through the protection step that still appears in the next sequence.

// File: rtl/pds_pkg.sv
// Shared definitions for the power domain sequencer.
// Assumes a 5-bit step encoding with idle at zero.
package pds_pkg;
    typedef enum logic [4:0] {
        ST_IDLE     = 5'd0,
        ST_UP_MAIN  = 5'd1,
        ST_UP_AUX   = 5'd2,
        ST_UP_WPWR  = 5'd3,
        ST_UP_CLK   = 5'd4,
        ST_UP_ISO   = 5'd5,
        ST_UP_RST   = 5'd6,
        ST_UP_SRAM  = 5'd7,
        ST_UP_WSRAM = 5'd8,
        ST_UP_PROT  = 5'd9,
        ST_UP_WPROT = 5'd10,
        ST_DN_PROT  = 5'd11,
        ST_DN_WPROT = 5'd12,
        ST_DN_SRAM  = 5'd13,
        ST_DN_WSRAM = 5'd14,
        ST_DN_ISO   = 5'd15,
        ST_DN_RST   = 5'd16,
        ST_DN_CLK   = 5'd17,
        ST_DN_MAIN  = 5'd18,
        ST_DN_AUX   = 5'd19,
        ST_DN_WPWR  = 5'd20
    } seq_state_e;

    localparam logic [15:0] CFG_KEY = 16'h0B16;
    localparam int          CFG_FIELD_LSB = 4;
endpackage

// File: rtl/pds_cfg_regs.sv
// Key-guarded mask registers for the sequencer.
// A write lands only with the key in the upper half and bit 0 set.
// Assumes both mask widths fit in the 12 bits above the field offset.
module pds_cfg_regs
    import pds_pkg::*;
#(
    parameter int SRAM_W = 4,
    parameter int PROT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              sel,
    input  logic [31:0]       wdata,
    output logic [SRAM_W-1:0] sram_mask,
    output logic [PROT_W-1:0] prot_mask
);
    logic key_ok;

    // Decide whether the write carries a valid key and enable bit
    always_comb key_ok = wr && (wdata[31:16] == CFG_KEY) && wdata[0];

    // Update the selected mask on an accepted write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sram_mask <= '0;
            prot_mask <= '0;
        end else if (key_ok) begin
            if (sel) prot_mask <= wdata[CFG_FIELD_LSB +: PROT_W];
            else     sram_mask <= wdata[CFG_FIELD_LSB +: SRAM_W];
        end
    end
endmodule

// File: rtl/pds_timer.sv
// Wait timeout counter: runs while a wait step is active and clears otherwise.
// Assumes wait steps are never adjacent, so the count restarts for each wait.
module pds_timer #(
    parameter int LIMIT = 25000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    // Count cycles spent in the current wait
    always_ff @(posedge clk) begin
        if (!rst_n || !active) cnt <= '0;
        else if (cnt != LAST)  cnt <= cnt + 1'b1;
    end

    // Flag the last permitted cycle of the wait
    always_comb expired = active && (cnt == LAST);
endmodule

// File: rtl/pds_fsm.sv
// Step sequencer: walks the power-up or power-down order, one output change
// per cycle, and polls the acknowledges between steps.
// Assumes masks are stable while a sequence runs.
module pds_fsm
    import pds_pkg::*;
#(
    parameter int SRAM_W = 4,
    parameter int PROT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_on,
    input  logic              pwr_ok_main,
    input  logic              pwr_ok_aux,
    input  logic [SRAM_W-1:0] sram_ack,
    input  logic [PROT_W-1:0] prot_ack,
    input  logic [SRAM_W-1:0] sram_mask,
    input  logic [PROT_W-1:0] prot_mask,
    input  logic              expired,
    output logic              wait_active,
    output logic              dom_rst_n,
    output logic              iso_en,
    output logic              sw_main,
    output logic              sw_aux,
    output logic              clk_gate,
    output logic [SRAM_W-1:0] sram_pd,
    output logic [PROT_W-1:0] prot_en,
    output logic              done,
    output logic              err,
    output seq_state_e        state
);
    logic on_q, known_q;
    logic pwr_all_on, pwr_all_off, sram_up_ok, sram_dn_ok, prot_up_ok, prot_dn_ok;
    logic prot_used;

    // Evaluate the completion conditions of every wait step
    always_comb begin
        pwr_all_on  = pwr_ok_main && pwr_ok_aux;
        pwr_all_off = !pwr_ok_main && !pwr_ok_aux;
        sram_up_ok  = (sram_ack & sram_mask) == '0;
        sram_dn_ok  = (sram_ack & sram_mask) == sram_mask;
        prot_up_ok  = (prot_ack & prot_mask) == '0;
        prot_dn_ok  = (prot_ack & prot_mask) == prot_mask;
        prot_used   = prot_mask != '0;
        wait_active = (state == ST_UP_WPWR)  || (state == ST_UP_WSRAM) ||
                      (state == ST_UP_WPROT) || (state == ST_DN_WPROT) ||
                      (state == ST_DN_WSRAM) || (state == ST_DN_WPWR);
    end

    // Advance the sequence and drive the registered control outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            dom_rst_n <= 1'b0;
            iso_en    <= 1'b1;
            sw_main   <= 1'b0;
            sw_aux    <= 1'b0;
            clk_gate  <= 1'b1;
            sram_pd   <= '1;
            prot_en   <= '0;
            done      <= 1'b0;
            err       <= 1'b0;
            on_q      <= 1'b0;
            known_q   <= 1'b1;
        end else begin
            done <= 1'b0;
            if (wait_active && expired) begin
                state   <= ST_IDLE;
                err     <= 1'b1;
                known_q <= 1'b0;
            end
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    err <= 1'b0;
                    if (known_q && (req_on == on_q)) done  <= 1'b1;
                    else if (req_on)                 state <= ST_UP_MAIN;
                    else if (prot_used)              state <= ST_DN_PROT;
                    else                             state <= ST_DN_SRAM;
                end
                ST_UP_MAIN: begin sw_main   <= 1'b1; state <= ST_UP_AUX;  end
                ST_UP_AUX:  begin sw_aux    <= 1'b1; state <= ST_UP_WPWR; end
                ST_UP_WPWR: if (pwr_all_on) state <= ST_UP_CLK;
                ST_UP_CLK:  begin clk_gate  <= 1'b0; state <= ST_UP_ISO;  end
                ST_UP_ISO:  begin iso_en    <= 1'b0; state <= ST_UP_RST;  end
                ST_UP_RST:  begin dom_rst_n <= 1'b1; state <= ST_UP_SRAM; end
                ST_UP_SRAM: begin sram_pd   <= '0;   state <= ST_UP_WSRAM; end
                ST_UP_WSRAM: if (sram_up_ok) begin
                    if (prot_used) state <= ST_UP_PROT;
                    else begin
                        state <= ST_IDLE; done <= 1'b1; on_q <= 1'b1; known_q <= 1'b1;
                    end
                end
                ST_UP_PROT: begin prot_en <= '0; state <= ST_UP_WPROT; end
                ST_UP_WPROT: if (prot_up_ok) begin
                    state <= ST_IDLE; done <= 1'b1; on_q <= 1'b1; known_q <= 1'b1;
                end
                ST_DN_PROT:  begin prot_en <= prot_mask; state <= ST_DN_WPROT; end
                ST_DN_WPROT: if (prot_dn_ok) state <= ST_DN_SRAM;
                ST_DN_SRAM:  begin sram_pd <= '1; state <= ST_DN_WSRAM; end
                ST_DN_WSRAM: if (sram_dn_ok) state <= ST_DN_ISO;
                ST_DN_ISO:  begin iso_en    <= 1'b1; state <= ST_DN_RST;  end
                ST_DN_RST:  begin dom_rst_n <= 1'b0; state <= ST_DN_CLK;  end
                ST_DN_CLK:  begin clk_gate  <= 1'b1; state <= ST_DN_MAIN; end
                ST_DN_MAIN: begin sw_main   <= 1'b0; state <= ST_DN_AUX;  end
                ST_DN_AUX:  begin sw_aux    <= 1'b0; state <= ST_DN_WPWR; end
                ST_DN_WPWR: if (pwr_all_off) begin
                    state <= ST_IDLE; done <= 1'b1; on_q <= 1'b0; known_q <= 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pwr_domain_seq.sv
// Top level of the power domain sequencer: mask registers, step FSM and
// wait timeout counter. Assumes all status inputs are synchronous to clk.
module pwr_domain_seq
    import pds_pkg::*;
#(
    parameter int SRAM_W     = 4,
    parameter int PROT_W     = 8,
    parameter int CLK_MHZ    = 250,
    parameter int TIMEOUT_US = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_on,
    input  logic              cfg_wr,
    input  logic              cfg_sel,
    input  logic [31:0]       cfg_wdata,
    input  logic              pwr_ok_main,
    input  logic              pwr_ok_aux,
    input  logic [SRAM_W-1:0] sram_ack,
    input  logic [PROT_W-1:0] prot_ack,
    output logic              dom_rst_n,
    output logic              iso_en,
    output logic              sw_main,
    output logic              sw_aux,
    output logic              clk_gate,
    output logic [SRAM_W-1:0] sram_pd,
    output logic [PROT_W-1:0] prot_en,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [4:0]        seq_state
);
    localparam int LIMIT = CLK_MHZ * TIMEOUT_US;

    logic [SRAM_W-1:0] sram_mask;
    logic [PROT_W-1:0] prot_mask;
    logic              wait_active, expired;
    seq_state_e        state;

    pds_cfg_regs #(.SRAM_W(SRAM_W), .PROT_W(PROT_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .sel(cfg_sel), .wdata(cfg_wdata),
        .sram_mask(sram_mask), .prot_mask(prot_mask)
    );

    pds_timer #(.LIMIT(LIMIT)) u_timer (
        .clk(clk), .rst_n(rst_n), .active(wait_active), .expired(expired)
    );

    pds_fsm #(.SRAM_W(SRAM_W), .PROT_W(PROT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_on(req_on),
        .pwr_ok_main(pwr_ok_main), .pwr_ok_aux(pwr_ok_aux),
        .sram_ack(sram_ack), .prot_ack(prot_ack),
        .sram_mask(sram_mask), .prot_mask(prot_mask),
        .expired(expired), .wait_active(wait_active),
        .dom_rst_n(dom_rst_n), .iso_en(iso_en), .sw_main(sw_main), .sw_aux(sw_aux),
        .clk_gate(clk_gate), .sram_pd(sram_pd), .prot_en(prot_en),
        .done(done), .err(err), .state(state)
    );

    // Expose the step encoding and the busy indication
    always_comb begin
        seq_state = state;
        busy      = (state != ST_IDLE);
    end
endmodule

// File: rtl/pds_checker.sv
// Protocol checker for the power domain sequencer, bound to the top module.
module pds_checker #(
    parameter int SRAM_W = 4,
    parameter int PROT_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dom_rst_n,
    input logic              iso_en,
    input logic              sw_main,
    input logic              sw_aux,
    input logic              clk_gate,
    input logic [SRAM_W-1:0] sram_pd,
    input logic [PROT_W-1:0] prot_en,
    input logic              pwr_ok_main,
    input logic              pwr_ok_aux,
    input logic [SRAM_W-1:0] sram_ack,
    input logic [SRAM_W-1:0] sram_mask,
    input logic              busy,
    input logic              done,
    input logic              err
);
    // R2 R6
    one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({dom_rst_n != $past(dom_rst_n), iso_en != $past(iso_en),
                    sw_main != $past(sw_main), sw_aux != $past(sw_aux),
                    clk_gate != $past(clk_gate), sram_pd != $past(sram_pd),
                    prot_en != $past(prot_en)}) <= 1);

    // R2
    aux_after_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_aux) |-> sw_main);

    // R3
    iso_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(iso_en) |-> (pwr_ok_main && pwr_ok_aux && !clk_gate));

    // R6
    switch_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sw_main) |-> (iso_en && !dom_rst_n && clk_gate));

    // R7
    sram_before_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(iso_en) |-> ((sram_ack & sram_mask) == sram_mask));

    // R13
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R9
    err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> !busy && !done);
endmodule

bind pwr_domain_seq pds_checker #(.SRAM_W(SRAM_W), .PROT_W(PROT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .dom_rst_n(dom_rst_n), .iso_en(iso_en),
    .sw_main(sw_main), .sw_aux(sw_aux), .clk_gate(clk_gate), .sram_pd(sram_pd),
    .prot_en(prot_en), .pwr_ok_main(pwr_ok_main), .pwr_ok_aux(pwr_ok_aux),
    .sram_ack(sram_ack), .sram_mask(sram_mask), .busy(busy), .done(done), .err(err)
);

// File: tb/tb_pwr_domain_seq.sv
// Directed bench for the power domain sequencer with a reactive model of
// the switches, SRAM macros and interconnect.
module tb_pwr_domain_seq;
    localparam int SRAM_W = 4;
    localparam int PROT_W = 8;
    localparam int LIMIT  = 250 * 100;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_on = 1'b0;
    logic cfg_wr = 1'b0, cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic pwr_ok_main = 1'b0, pwr_ok_aux = 1'b0;
    logic [SRAM_W-1:0] sram_ack = '0;
    logic [PROT_W-1:0] prot_ack = '0;
    logic dom_rst_n, iso_en, sw_main, sw_aux, clk_gate, busy, done, err;
    logic [SRAM_W-1:0] sram_pd;
    logic [PROT_W-1:0] prot_en;
    logic [4:0] seq_state;

    // environment overrides
    logic aux_hold = 1'b0;
    logic [SRAM_W-1:0] sram_hi = '0, sram_lo = '0;
    logic [PROT_W-1:0] prot_hi = '0, prot_lo = '0;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    int ev_log[$];

    pwr_domain_seq #(.SRAM_W(SRAM_W), .PROT_W(PROT_W)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_on(req_on),
        .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .pwr_ok_main(pwr_ok_main), .pwr_ok_aux(pwr_ok_aux),
        .sram_ack(sram_ack), .prot_ack(prot_ack),
        .dom_rst_n(dom_rst_n), .iso_en(iso_en), .sw_main(sw_main), .sw_aux(sw_aux),
        .clk_gate(clk_gate), .sram_pd(sram_pd), .prot_en(prot_en),
        .busy(busy), .done(done), .err(err), .seq_state(seq_state)
    );

    initial forever #2 clk = ~clk;

    // environment model: status follows outputs one half cycle later
    initial forever begin
        @(negedge clk);
        pwr_ok_main = sw_main;
        pwr_ok_aux  = sw_aux & ~aux_hold;
        sram_ack    = (sram_pd & ~sram_lo) | sram_hi;
        prot_ack    = (prot_en & ~prot_lo) | prot_hi;
    end

    // change monitor: code = group*2 + new value, 99 for several at once
    initial begin
        logic [6:0] prev, cur;
        prev = '0;
        forever begin
            @(negedge clk);
            cur = {|prot_en, |sram_pd, dom_rst_n, iso_en, clk_gate, sw_aux, sw_main};
            if (rst_n) begin
                if ($countones(cur ^ prev) > 1) ev_log.push_back(99);
                else for (int i = 0; i < 7; i++)
                    if (cur[i] != prev[i]) ev_log.push_back(i * 2 + int'(cur[i]));
            end
            prev = cur;
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not end, actual running expected finished");
        summary();
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic check_log(input string tag, input int exp[$]);
        n_chk++;
        if (ev_log != exp) begin
            n_fail++;
            $display("FAIL %s: actual log %p expected %p", tag, ev_log, exp);
        end
        ev_log.delete();
    endtask

    task automatic request(input logic on);
        @(negedge clk); req_valid = 1'b1; req_on = on;
        @(negedge clk); req_valid = 1'b0;
    endtask

    task automatic cfg_write(input logic sel, input logic [15:0] key,
                             input logic [11:0] mask, input logic en);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel;
        cfg_wdata = {key, mask, 3'b000, en};
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    // wait for done; returns negedges counted from the request negedge
    task automatic wait_done(input string tag, output int cycles);
        cycles = 1;
        while (!done && cycles < 1000) begin @(negedge clk); cycles++; end
        if (!done) chk(tag, 32'(done), 32'd1);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        ev_log.delete();
        chk("R1 reset outputs",
            {dom_rst_n, iso_en, sw_main, sw_aux, clk_gate, 4'(sram_pd)},
            {1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'hF});
        chk("R1 reset prot_en", 32'(prot_en), 32'd0);
        chk("R1 reset flags", {busy, done, err}, 3'b000);
        chk("R1 reset state", 32'(seq_state), 32'd0);
    endtask

    task automatic t_power_up_first();
        int c;
        cfg_write(1'b0, 16'h0B16, 12'h003, 1'b1);
        cfg_write(1'b1, 16'h0B16, 12'h00F, 1'b1);
        aux_hold = 1'b1; sram_hi = 4'b1001;
        request(1'b1);
        repeat (15) @(negedge clk);
        chk("R3 status disagreement keeps waiting", {busy, clk_gate, iso_en}, 3'b111);
        aux_hold = 1'b0;
        repeat (12) @(negedge clk);
        chk("R4 masked SRAM ack holds sequence", {busy, dom_rst_n, 4'(sram_pd)}, {2'b11, 4'h0});
        sram_hi = 4'b1000;
        wait_done("R4 unmasked ack ignored", c);
        chk("R13 busy low at done", 32'(busy), 32'd0);
        @(negedge clk);
        chk("R13 done is one cycle", 32'(done), 32'd0);
        check_log("R2 power-up order", '{1, 3, 4, 6, 9, 10});
        chk("R2 final on outputs", {dom_rst_n, iso_en, sw_main, sw_aux, clk_gate},
            5'b10110);
        sram_hi = '0;
    endtask

    task automatic t_power_down();
        int c;
        prot_lo = 8'h01; sram_lo = 4'b0010;
        request(1'b0);
        repeat (10) @(negedge clk);
        chk("R7 protection ack gates SRAM", {busy, 4'(sram_pd), 8'(prot_en)},
            {1'b1, 4'h0, 8'h0F});
        @(negedge clk); req_valid = 1'b1; req_on = 1'b1;
        @(negedge clk); req_valid = 1'b0;
        prot_lo = '0;
        repeat (10) @(negedge clk);
        chk("R7 SRAM ack gates isolation", {busy, iso_en, 4'(sram_pd)}, {2'b10, 4'hF});
        sram_lo = '0;
        wait_done("R6 power-down completes", c);
        repeat (2) @(negedge clk);
        check_log("R6 power-down order", '{13, 11, 7, 8, 5, 0, 2});
        chk("R11 request during busy ignored", {sw_main, sw_aux, busy}, 3'b000);
    endtask

    task automatic t_same_state(input logic on, input string tag);
        request(on);
        chk({tag, " done next cycle"}, {done, busy}, 2'b10);
        @(negedge clk);
        check_log({tag, " no output change"}, '{});
    endtask

    task automatic t_key_and_release();
        int c;
        cfg_write(1'b1, 16'h0B17, 12'h000, 1'b1);
        cfg_write(1'b1, 16'h0B16, 12'h000, 1'b0);
        prot_hi = 8'h02;
        request(1'b1);
        repeat (20) @(negedge clk);
        chk("R5 release waits for masked ack low", {busy, 8'(prot_en)}, {1'b1, 8'h00});
        prot_hi = '0;
        wait_done("R5 release completes", c);
        repeat (2) @(negedge clk);
        check_log("R10 rejected writes keep protection step", '{1, 3, 4, 6, 9, 10, 12});
    endtask

    task automatic t_skip();
        int c;
        cfg_write(1'b1, 16'h0B16, 12'h000, 1'b1);
        cfg_write(1'b0, 16'h0B16, 12'h000, 1'b1);
        sram_lo = 4'hF;
        @(negedge clk); req_valid = 1'b1; req_on = 1'b0;
        @(negedge clk); req_valid = 1'b0;
        wait_done("R8 skip", c);
        chk("R8 zero masks: done cycle", 32'(c), 32'd9);
        repeat (2) @(negedge clk);
        check_log("R8 no protection change", '{11, 7, 8, 5, 0, 2});
        sram_lo = '0;
    endtask

    task automatic t_timeout();
        int c;
        aux_hold = 1'b1;
        request(1'b1);
        repeat (LIMIT - 20) @(negedge clk);
        chk("R9 no early abort", {busy, err}, 2'b10);
        repeat (60) @(negedge clk);
        chk("R9 abort after limit", {busy, err, done}, 3'b010);
        chk("R9 outputs held", {sw_main, sw_aux, clk_gate, iso_en, dom_rst_n}, 5'b11110);
        repeat (5) @(negedge clk);
        chk("R9 error is sticky", 32'(err), 32'd1);
        aux_hold = 1'b0;
        request(1'b1);
        chk("R9 new request clears error", {err, busy}, 2'b01);
        wait_done("R9 retry completes", c);
        chk("R9 retry reaches on", {dom_rst_n, iso_en, clk_gate}, 3'b100);
        ev_log.delete();
    endtask

    initial begin
        t_reset();
        t_power_up_first();
        t_power_down();
        t_same_state(1'b0, "R12 off request when off");
        t_key_and_release();
        t_same_state(1'b1, "R12 on request when on");
        t_skip();
        t_timeout();
        repeat (3) @(negedge clk);
        summary();
    end
endmodule